// File: doc/BRIEF.md
# Nine-Bit Serial Register Writer

This block sends register writes to a display controller over a transmit-only serial link whose words are nine bits wide. Bit 8 of each word says whether the word is a command (register address) or a data byte. The host puts an address, up to two data bytes and a byte count on its inputs and pulses a start strobe. The block then sends the whole transaction inside one chip-select window and returns a one-cycle completion pulse.

The serial clock idles high. Output data changes on the falling edge and the receiver samples it on the rising edge, so the link runs in SPI mode 3. The serial clock rate comes from a parameter that sets how many system clocks make up one half-period of the serial clock. Chip select is given one half-period of setup before the first clock edge and one half-period of hold after the last one.

Top module: `spi9_writer`

## Requirements
- R1: After reset, cs_n_o and sck_o are high and busy_o and done_o are low.
- R2: The first word of every frame is a command word, with bit 8 = 0 and bits 7:0 = addr_i. Every later word is a data word, with bit 8 = 1 and a data byte in bits 7:0.
- R3: nbytes_i = 0 sends the command word alone. nbytes_i = 1 adds one data word carrying data_i[7:0]. nbytes_i = 2 adds data_i[15:8] followed by data_i[7:0]. nbytes_i = 3 is treated as 2.
- R4: Words go out most significant bit first. mosi_o changes only on a falling edge of sck_o, so it is stable at every rising edge. sck_o is high whenever cs_n_o is high.
- R5: cs_n_o goes low once per transaction and stays low until every word has been sent. A frame holds exactly 9 × (number of words) rising edges of sck_o.
- R6: Each low phase and each high phase of sck_o inside a frame lasts exactly HALF_DIV system clocks.
- R7: The first falling edge of sck_o comes exactly HALF_DIV clocks after cs_n_o falls. cs_n_o rises exactly HALF_DIV clocks after the last rising edge of sck_o.
- R8: busy_o is high from the clock after an accepted start until cs_n_o rises. done_o is high for exactly one clock, the same clock in which cs_n_o returns high.
- R9: A start pulse that arrives while busy_o is high is ignored. It changes neither the frame in progress nor the number of frames sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request; accepted only while idle |
| addr_i | input | 8 | Register address for the command word |
| data_i | input | 16 | Data bytes; [15:8] first when two bytes are sent |
| nbytes_i | input | 2 | Number of data bytes: 0, 1 or 2 (3 acts as 2) |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse when the frame ends |
| sck_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data out |
| cs_n_o | output | 1 | Chip select, active low |

## Verification
The bench builds the block with HALF_DIV = 3. Every phase then spans several system clocks, so a counter that is off by one in the divider, the setup or the hold shows up as a measured length of 2 or 4 instead of 3. A receiver model samples on rising edges and measures every phase. The bench sweeps every third address value across all four byte-count codes, with data derived from the address, and injects extra start pulses in the middle of frames to cover the ignore rule.

// File: rtl/spi9_pkg.sv
package spi9_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = BYTE_W + 1;
  localparam int MAX_DATA = 2;
  localparam int FRAME_W  = WORD_W * (1 + MAX_DATA);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_SHIFT = 2'd2,
    ST_HOLD  = 2'd3
  } spi9_state_e;
endpackage

// File: rtl/spi9_tick.sv
module spi9_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/spi9_shifter.sv
module spi9_shifter #(
  parameter int W = 27
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] load_val,
  output logic         msb
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else if (load) sr <= load_val;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign msb = sr[W-1];
endmodule

// File: rtl/spi9_frame_ctl.sv
module spi9_frame_ctl
  import spi9_pkg::*;
#(
  parameter int FW = FRAME_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] nwords,
  input  logic       tick,
  input  logic       serial_bit,
  output logic       load,
  output logic       shift,
  output logic       busy,
  output logic       sck,
  output logic       mosi,
  output logic       cs_n,
  output logic       done
);
  localparam int BCW = $clog2(FW);

  spi9_state_e    state;
  logic           ph_low;
  logic [BCW-1:0] bits_left;

  assign load  = (state == ST_IDLE) && start;
  assign shift = (state == ST_SHIFT) && tick && ph_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ph_low    <= 1'b0;
      bits_left <= '0;
      busy      <= 1'b0;
      sck       <= 1'b1;
      mosi      <= 1'b0;
      cs_n      <= 1'b1;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state     <= ST_SETUP;
          busy      <= 1'b1;
          cs_n      <= 1'b0;
          bits_left <= BCW'(WORD_W * int'(nwords) - 1);
        end
        ST_SETUP: if (tick) begin
          state  <= ST_SHIFT;
          sck    <= 1'b0;
          mosi   <= serial_bit;
          ph_low <= 1'b1;
        end
        ST_SHIFT: if (tick) begin
          if (ph_low) begin
            sck <= 1'b1;
            if (bits_left == '0) state <= ST_HOLD;
            else begin
              bits_left <= bits_left - 1'b1;
              ph_low    <= 1'b0;
            end
          end else begin
            sck    <= 1'b0;
            mosi   <= serial_bit;
            ph_low <= 1'b1;
          end
        end
        ST_HOLD: if (tick) begin
          state  <= ST_IDLE;
          ph_low <= 1'b0;
          cs_n   <= 1'b1;
          busy   <= 1'b0;
          done   <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sck);
  assert_mosi_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    $changed(mosi) |-> $fell(sck));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_with_cs_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> done);
  assert_idle_cs_R5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n);
endmodule

// File: rtl/spi9_writer.sv
module spi9_writer
  import spi9_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic [7:0]  addr_i,
  input  logic [15:0] data_i,
  input  logic [1:0]  nbytes_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        sck_o,
  output logic        mosi_o,
  output logic        cs_n_o
);
  logic [FRAME_W-1:0] frame;
  logic [1:0]         nwords;
  logic [WORD_W-1:0]  cmd_word, hi_word, lo_word;
  logic               tick, load, shift, serial_bit;

  assign cmd_word = {1'b0, addr_i};
  assign hi_word  = {1'b1, data_i[2*BYTE_W-1:BYTE_W]};
  assign lo_word  = {1'b1, data_i[BYTE_W-1:0]};

  always_comb begin
    case (nbytes_i)
      2'd0: begin
        nwords = 2'd1;
        frame  = {cmd_word, {(2*WORD_W){1'b0}}};
      end
      2'd1: begin
        nwords = 2'd2;
        frame  = {cmd_word, lo_word, {WORD_W{1'b0}}};
      end
      default: begin
        nwords = 2'd3;
        frame  = {cmd_word, hi_word, lo_word};
      end
    endcase
  end

  spi9_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst(rst), .run(busy_o), .tick(tick)
  );

  spi9_shifter #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .shift(shift),
    .load_val(frame), .msb(serial_bit)
  );

  spi9_frame_ctl #(.FW(FRAME_W)) u_ctl (
    .clk(clk), .rst(rst), .start(start_i), .nwords(nwords),
    .tick(tick), .serial_bit(serial_bit), .load(load), .shift(shift),
    .busy(busy_o), .sck(sck_o), .mosi(mosi_o), .cs_n(cs_n_o), .done(done_o)
  );

  assert_busy_after_start_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> busy_o);
endmodule

// File: tb/spi9_writer_test.sv
module spi9_writer_test;
  localparam int H = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [15:0] data_i = '0;
  logic [1:0]  nbytes_i = '0;
  logic        busy_o, done_o, sck_o, mosi_o, cs_n_o;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  spi9_writer #(.HALF_DIV(H)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i),
    .data_i(data_i), .nbytes_i(nbytes_i), .busy_o(busy_o),
    .done_o(done_o), .sck_o(sck_o), .mosi_o(mosi_o), .cs_n_o(cs_n_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // receiver model, sampled at the falling system clock edge
  int cyc = 0;
  logic prev_sck = 1'b1, prev_cs = 1'b1, first_fall = 1'b0, mosi_at_fall = 1'b0;
  int t_csfall = 0, t_fall = 0, t_rise = 0, nbits = 0, frames = 0;
  logic [26:0] cap = '0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (cs_n_o && !sck_o) chk(1'b0, "R4 sck idle", 0, 1);
      if (prev_cs && !cs_n_o) begin
        t_csfall = cyc; nbits = 0; cap = '0; first_fall = 1'b1;
      end else if (!cs_n_o) begin
        chk(busy_o, "R8 busy in frame", int'(busy_o), 1);
        if (prev_sck && !sck_o) begin
          if (first_fall) chk(cyc - t_csfall == H, "R7 setup", cyc - t_csfall, H);
          else chk(cyc - t_rise == H, "R6 high phase", cyc - t_rise, H);
          first_fall = 1'b0; t_fall = cyc; mosi_at_fall = mosi_o;
        end else if (!prev_sck && sck_o) begin
          chk(cyc - t_fall == H, "R6 low phase", cyc - t_fall, H);
          chk(mosi_o == mosi_at_fall, "R4 mosi stable", int'(mosi_o), int'(mosi_at_fall));
          cap = {cap[25:0], mosi_o}; nbits++; t_rise = cyc;
        end
      end else if (!prev_cs && cs_n_o) begin
        chk(cyc - t_rise == H, "R7 hold", cyc - t_rise, H);
        chk(done_o, "R8 done at cs rise", int'(done_o), 1);
        chk(!busy_o, "R8 busy drop", int'(busy_o), 0);
        frames++;
      end
    end
    prev_sck = sck_o; prev_cs = cs_n_o;
  end

  task automatic run_frame(input logic [7:0] a, input logic [15:0] d,
                           input logic [1:0] n, input bit inject);
    int f0, words;
    logic [26:0] exp;
    words = (n == 0) ? 1 : (n == 1) ? 2 : 3;
    if (n == 0) exp = {18'd0, 1'b0, a};
    else if (n == 1) exp = {9'd0, 1'b0, a, 1'b1, d[7:0]};
    else exp = {1'b0, a, 1'b1, d[15:8], 1'b1, d[7:0]};
    f0 = frames;
    @(negedge clk);
    addr_i = a; data_i = d; nbytes_i = n; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, "R8 busy after start", int'(busy_o), 1);
    if (inject) begin
      repeat (5) @(negedge clk);
      addr_i = ~a; data_i = ~d; nbytes_i = 2'd0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    do @(posedge clk); while (frames == f0);
    chk(nbits == 9 * words, "R5 bit count", nbits, 9 * words);
    chk(cap == exp, "R2 R3 frame content", int'(cap), int'(exp));
    @(negedge clk);
    chk(!done_o, "R8 done one cycle", int'(done_o), 0);
    if (inject) begin
      repeat (4 * H) @(negedge clk);
      chk(frames == f0 + 1 && cs_n_o, "R9 start ignored", frames - f0, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n_o && sck_o && !busy_o && !done_o, "R1 reset state",
        {28'd0, cs_n_o, sck_o, busy_o, done_o}, 4'b1100);
    run_frame(8'h00, 16'h0000, 2'd0, 1'b0);
    run_frame(8'hff, 16'hffff, 2'd2, 1'b0);
    run_frame(8'h5a, 16'h12a5, 2'd1, 1'b0);
    run_frame(8'hb8, 16'hfff9, 2'd3, 1'b0);  // R3 code 3 acts as 2
    for (int a = 0; a < 256; a += 3) begin
      for (int n = 0; n < 4; n++) begin
        run_frame(8'(a), 16'((a * 40503 + n * 771) ^ 16'h9c3a), 2'(n), (a % 9) == 0);
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R8 watchdog actual=hang expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule